// File: doc/BRIEF.md
# Wide Receive Residue Byte Handler

This block converts a 16-bit receive word stream into a byte stream for memory writes. Each transfer is started by a move command that carries a byte count and a chained/normal selector. The count is always measured in memory bytes. Each bus word yields its low byte and then its high byte. When a move needs an odd number of bytes from the bus, the last word is only half used, and its high byte is left over.

A chained move keeps that leftover byte in a holding register and raises a sticky residue flag. A later chained move that starts with the flag raised sends the held byte to memory first, and that byte counts toward the new move's count. A normal move never reads the holding register. It discards any leftover high byte at its own end. Any move with a nonzero count clears the flag when it starts. Software may also clear the flag at any time through a dedicated pin.

Both data interfaces use valid/ready handshakes. A word or byte transfers on a clock edge where valid and ready are both high. Once the block raises `byte_valid`, it keeps `byte_data` unchanged until the memory side accepts it. The block raises `word_ready` only while it is waiting for a bus word, and never in the same cycle as `byte_valid`. The word source may hold `word_valid` low for any number of cycles. The memory side may hold `byte_ready` low for any number of cycles.

Top module: `wide_rx_residue`

## Requirements
- R1: The low byte of each accepted word (bits 7:0) is emitted before its high byte (bits 15:8).
- R2: A move emits exactly its byte count of bytes. It accepts only as many words as it needs: the bus bytes needed are the count minus one if the held byte is drained, otherwise the count, and the words accepted are that number rounded up to an even number and halved.
- R3: `cmd_done` is high for exactly one cycle. That cycle is the one after the edge on which the last counted byte was accepted.
- R4: A move with byte count zero raises `cmd_done` in the cycle after its start. It accepts no word, emits no byte, and leaves the flag and the held byte unchanged.
- R5: A chained move that ends on the low byte of a word raises `resid_flag` and stores that word's high byte. That byte is not emitted.
- R6: A normal move that ends on the low byte of a word discards the high byte, and `resid_flag` stays low.
- R7: A chained move that starts with `resid_flag` high emits the held byte first, and that byte is one of its counted bytes. A count of one then accepts no word.
- R8: A chained move that starts with `resid_flag` low behaves exactly like a normal move from its first byte onward.
- R9: A normal move that starts with `resid_flag` high ignores the held byte. Its first byte comes from the bus.
- R10: A move with a nonzero count clears `resid_flag` when it is accepted, unless it raises the flag again at its end.
- R11: A `resid_clr` pulse clears `resid_flag` on the next edge. The held byte is then never drained. If a capture happens on the same edge, the capture wins.
- R12: `byte_data` stays stable while `byte_valid` is high and `byte_ready` is low. A `cmd_start` that arrives while a move is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Move command strobe; accepted only while idle |
| cmd_chain | input | 1 | 1 = chained move, 0 = normal move |
| cmd_count | input | CNT_W | Byte count of the move, in memory bytes |
| word_valid | input | 1 | Bus word available |
| word_ready | output | 1 | Block accepts a bus word |
| word_data | input | 2*BYTE_W | Bus word; low byte in bits 7:0 |
| byte_valid | output | 1 | Memory byte available |
| byte_ready | input | 1 | Memory side accepts the byte |
| byte_data | output | BYTE_W | Memory byte |
| cmd_done | output | 1 | One-cycle completion pulse |
| resid_flag | output | 1 | Residue byte held |
| resid_clr | input | 1 | Software clear of the residue flag |

## Verification
The bench focuses on where a move starts and where it ends. One case is a chained move with count one and the flag raised. A design that forgot the drained byte counts toward the total would take an extra bus word. A normal move that starts with the flag raised would emit a stale byte if the held byte leaked into it. A zero-count move that started a transfer anyway would clear the flag or wait for a word that never arrives. A flag cleared by software, and a start strobe given during a busy move, are each followed by a move whose output shows whether the held byte or the old command still has any effect.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_FETCH,
    ST_LO,
    ST_HI,
    ST_DONE
  } wrr_state_e;
endpackage

// File: rtl/wrr_count.sv
module wrr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             rem_one
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    rem_q <= '0;
    else if (load) rem_q <= load_val;
    else if (dec)  rem_q <= rem_q - CNT_W'(1);
  end

  assign rem_one = (rem_q == CNT_W'(1));

  // R2: a byte is never taken when nothing remains
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (rem_q != '0));
endmodule

// File: rtl/wrr_residue.sv
module wrr_residue #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              capture,
  input  logic [BYTE_W-1:0] cap_byte,
  input  logic              sw_clr,
  output logic              flag,
  output logic [BYTE_W-1:0] hold
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      hold <= '0;
    end else begin
      if (capture) begin
        flag <= 1'b1;
        hold <= cap_byte;
      end else if (sw_clr || xfer_start) begin
        flag <= 1'b0;
      end
    end
  end

  a_r5_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (flag && hold == $past(cap_byte)));
  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !capture) |=> !flag);
  a_r11_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && !capture) |=> !flag);
  a_r11_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(hold));
endmodule

// File: rtl/wrr_ctrl.sv
module wrr_ctrl
  import wrr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_chain,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic [BYTE_W-1:0] byte_data,
  output logic              cmd_done,
  input  logic              resid_flag,
  input  logic [BYTE_W-1:0] resid_hold,
  input  logic              rem_one,
  output logic              cnt_load,
  output logic              cnt_dec,
  output logic              xfer_start,
  output logic              capture,
  output logic [BYTE_W-1:0] cap_byte
);
  wrr_state_e        st_q, st_d;
  logic              chain_q;
  logic [WORD_W-1:0] word_q;
  logic              accept_start, byte_fire, word_fire, cnt_zero;

  assign cnt_zero     = (cmd_count == '0);
  assign accept_start = (st_q == ST_IDLE) && cmd_start;
  assign byte_valid   = (st_q == ST_DRAIN) || (st_q == ST_LO) || (st_q == ST_HI);
  assign word_ready   = (st_q == ST_FETCH);
  assign cmd_done     = (st_q == ST_DONE);
  assign byte_fire    = byte_valid && byte_ready;
  assign word_fire    = word_valid && word_ready;

  assign cnt_load   = accept_start;
  assign cnt_dec    = byte_fire;
  assign xfer_start = accept_start && !cnt_zero;
  assign capture    = (st_q == ST_LO) && byte_fire && rem_one && chain_q;
  assign cap_byte   = word_q[WORD_W-1:BYTE_W];

  always_comb begin
    unique case (st_q)
      ST_DRAIN: byte_data = resid_hold;
      ST_LO:    byte_data = word_q[BYTE_W-1:0];
      default:  byte_data = word_q[WORD_W-1:BYTE_W];
    endcase
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_start) begin
          if (cnt_zero)                    st_d = ST_DONE;
          else if (cmd_chain && resid_flag) st_d = ST_DRAIN;
          else                             st_d = ST_FETCH;
        end
      end
      ST_DRAIN: if (byte_fire) st_d = rem_one ? ST_DONE : ST_FETCH;
      ST_FETCH: if (word_fire) st_d = ST_LO;
      ST_LO:    if (byte_fire) st_d = rem_one ? ST_DONE : ST_HI;
      ST_HI:    if (byte_fire) st_d = rem_one ? ST_DONE : ST_FETCH;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      chain_q <= 1'b0;
      word_q  <= '0;
    end else begin
      st_q <= st_d;
      if (accept_start) chain_q <= cmd_chain;
      if (word_fire)    word_q  <= word_data;
    end
  end

  a_r12_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);
  a_r4_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_start && cnt_zero) |=> (cmd_done && !byte_valid && !word_ready));
  a_r7_drain_first: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_start && !cnt_zero && cmd_chain && resid_flag)
      |=> (byte_valid && byte_data == $past(resid_hold)));
  a_r9_normal_bus_first: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_start && !cnt_zero && !cmd_chain) |=> word_ready);
endmodule

// File: rtl/wide_rx_residue.sv
module wide_rx_residue #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_start,
  input  logic                cmd_chain,
  input  logic [CNT_W-1:0]    cmd_count,
  input  logic                word_valid,
  output logic                word_ready,
  input  logic [2*BYTE_W-1:0] word_data,
  output logic                byte_valid,
  input  logic                byte_ready,
  output logic [BYTE_W-1:0]   byte_data,
  output logic                cmd_done,
  output logic                resid_flag,
  input  logic                resid_clr
);
  logic              rem_one, cnt_load, cnt_dec, xfer_start, capture;
  logic [BYTE_W-1:0] cap_byte, resid_hold;

  wrr_ctrl #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_start(cmd_start), .cmd_chain(cmd_chain), .cmd_count(cmd_count),
    .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .cmd_done(cmd_done), .resid_flag(resid_flag), .resid_hold(resid_hold),
    .rem_one(rem_one), .cnt_load(cnt_load), .cnt_dec(cnt_dec),
    .xfer_start(xfer_start), .capture(capture), .cap_byte(cap_byte)
  );

  wrr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cmd_count),
    .dec(cnt_dec), .rem_one(rem_one)
  );

  wrr_residue #(.BYTE_W(BYTE_W)) u_residue (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .capture(capture),
    .cap_byte(cap_byte), .sw_clr(resid_clr), .flag(resid_flag),
    .hold(resid_hold)
  );
endmodule

// File: tb/wide_rx_residue_tb.sv
`timescale 1ns/1ps
module wide_rx_residue_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0, cmd_chain = 1'b0;
  logic [15:0] cmd_count = '0;
  logic        word_valid = 1'b0, word_ready;
  logic [15:0] word_data = '0;
  logic        byte_valid, byte_ready = 1'b0;
  logic [7:0]  byte_data;
  logic        cmd_done, resid_flag;
  logic        resid_clr = 1'b0;

  int total = 0, bad = 0, cyc = 0, wptr = 0;
  bit ref_flag = 1'b0;
  logic [7:0] ref_hold = '0;

  always #2.5 clk = ~clk;

  wide_rx_residue u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_chain(cmd_chain),
    .cmd_count(cmd_count), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .cmd_done(cmd_done), .resid_flag(resid_flag),
    .resid_clr(resid_clr)
  );

  function automatic logic [15:0] wgen(int k);
    return {8'(k * 7 + 8'h91), 8'(k * 5 + 8'h2C)};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One move: builds the expected stream, runs the handshakes with stalls, checks.
  task automatic run_move(bit chain, int count, bit poke, string rb, string rf);
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    int n = count, k = wptr, exp_words, words = 0, start_cyc, last_acc, done_cyc = -1;
    if (n > 0) begin
      if (chain && ref_flag) begin exp_q.push_back(ref_hold); n--; end
      ref_flag = 1'b0;
      while (n > 0) begin
        exp_q.push_back(wgen(k)[7:0]); n--;
        if (n == 0) begin
          if (chain) begin ref_hold = wgen(k)[15:8]; ref_flag = 1'b1; end
          k++;
          break;
        end
        exp_q.push_back(wgen(k)[15:8]); n--; k++;
      end
    end
    exp_words = k - wptr;

    @(negedge clk); cyc++;
    cmd_start = 1'b1; cmd_chain = chain; cmd_count = 16'(count);
    start_cyc = cyc; last_acc = cyc;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk); cyc++;
      cmd_start = 1'b0;
      if (poke && cyc == start_cyc + 3) begin
        cmd_start = 1'b1; cmd_chain = ~chain; cmd_count = 16'd7;
      end
      if (cmd_done) begin done_cyc = cyc; break; end
      byte_ready = ((cyc % 4) != 2);
      word_valid = ((cyc % 3) != 1);
      word_data  = wgen(wptr);
      if (byte_valid && byte_ready) begin got_q.push_back(byte_data); last_acc = cyc; end
      if (word_valid && word_ready) begin wptr++; words++; end
    end
    byte_ready = 1'b0; word_valid = 1'b0; cmd_start = 1'b0;

    chk(got_q.size() == exp_q.size(), rb, "byte count", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], rb, $sformatf("byte %0d", i), got_q[i], exp_q[i]);
    chk(words == exp_words, rb, "words taken", words, exp_words);
    chk(done_cyc == last_acc + 1, "R3", "done cycle", done_cyc - start_cyc, last_acc + 1 - start_cyc);
    chk(resid_flag == ref_flag, rf, "residue flag", resid_flag, ref_flag);
    @(negedge clk); cyc++;
    chk(!cmd_done, "R3", "done width", cmd_done, 0);
  endtask

  task automatic t_reset();
    chk(!resid_flag, "R10", "reset flag", resid_flag, 0);
    chk(!cmd_done, "R3", "reset done", cmd_done, 0);
    chk(!byte_valid && !word_ready, "R12", "reset idle", byte_valid, 0);
  endtask

  task automatic t_even_normal();  run_move(1'b0, 6, 1'b0, "R1", "R6"); endtask
  task automatic t_odd_normal();   run_move(1'b0, 5, 1'b0, "R2", "R6"); endtask
  task automatic t_odd_chain();    run_move(1'b1, 3, 1'b0, "R8", "R5"); endtask
  task automatic t_zero_chain();   run_move(1'b1, 0, 1'b0, "R4", "R4"); endtask
  task automatic t_drain();
    run_move(1'b1, 4, 1'b0, "R7", "R5");
    run_move(1'b1, 1, 1'b0, "R7", "R10");
  endtask
  task automatic t_normal_ignores();
    run_move(1'b1, 1, 1'b0, "R5", "R5");
    run_move(1'b0, 4, 1'b0, "R9", "R10");
  endtask
  task automatic t_sw_clear();
    run_move(1'b1, 5, 1'b0, "R5", "R5");
    @(negedge clk); cyc++; resid_clr = 1'b1;
    @(negedge clk); cyc++; resid_clr = 1'b0;
    ref_flag = 1'b0;
    chk(!resid_flag, "R11", "flag after clear", resid_flag, 0);
    run_move(1'b1, 2, 1'b0, "R11", "R11");
  endtask
  task automatic t_busy_poke();
    run_move(1'b0, 10, 1'b1, "R12", "R12");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); cyc++;
      chk(!byte_valid && !word_ready && !cmd_done, "R12", "idle after poke", byte_valid, 0);
    end
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); cyc++;
    t_reset();
    t_even_normal();
    t_odd_normal();
    t_odd_chain();
    t_zero_chain();
    t_drain();
    t_normal_ignores();
    t_sw_clear();
    t_busy_poke();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule